// File: doc/BRIEF.md
# Four-Channel Request-Triggered Memory Mover

This block moves data between memory locations on behalf of a processor, one unit per request. It holds four independent channels. Each channel is programmed with a source address, a destination address, a remaining unit count, a unit size and an address-stepping mode. Software sets a channel up through a small register write port. From then on the channel is fired by a request line of the kind that would otherwise raise an interrupt.

Each accepted request makes the engine perform exactly one transfer: a read of one unit from the source address, then a write of that unit to the destination address. For those two bus cycles the engine raises a hold line that suspends the processor core. After the write, the count drops by one and the addresses step by the unit size as the mode selects. When the count reaches zero the channel raises its done flag and stays deaf to requests until software writes a new count.

The memory master port has fixed timing and no back-pressure. A read issued in one cycle must return its data on `bus_rdata` in the next cycle. A write is taken in the cycle it is issued. The processor side has no handshake either. `cpu_hold` is a plain level that the core must honour at once.

Top module: `udma_quad`

## Requirements
- R1: After reset, `cpu_hold`, `bus_req` and every `ch_done` bit are 0, and every channel has a count of zero.
- R2: A write with `cfg_we`=1 loads the register picked by `cfg_sel` of channel `cfg_ch`: 0 = source address, 1 = destination address, 2 = count (low 16 bits), 3 = control (bits 1:0 size, bits 3:2 mode). A single trigger on a channel with count 3, size byte and mode 0 copies one byte. Three such triggers copy three consecutive bytes.
- R3: Size code 0 moves 1 byte, code 1 moves 2 bytes, code 2 (and the spare code 3) moves 4 bytes. Every address step equals the unit size.
- R4: Mode 1 steps only the destination address. The source stays fixed.
- R5: Mode 2 steps only the source address. The destination stays fixed. Mode 0 (and the spare code 3) steps both.
- R6: When a transfer brings the count to zero, the channel's `ch_done` bit goes to 1. Later triggers on that channel cause no bus cycle.
- R7: Writing a channel's count clears its `ch_done` bit and re-arms it.
- R8: When several channels have requests pending, the lowest-numbered channel is served first. The others follow in turn.
- R9: Each transfer is one read cycle (`bus_req`=1, `bus_wr`=0, source address), followed in the next cycle by one write cycle (`bus_req`=1, `bus_wr`=1, destination address, data read). `cpu_hold` is 1 during exactly those two cycles.
- R10: A trigger on a channel whose count is zero starts no transfer.
- R11: A trigger that arrives in the same cycle as the write that empties the channel is dropped. It causes no further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel picked by the write |
| cfg_sel | input | 2 | Register picked within the channel |
| cfg_data | input | 32 | Write data |
| irq_req | input | 4 | Per-channel request lines, sampled each clock |
| cpu_hold | output | 1 | Suspends the processor while a transfer runs |
| bus_req | output | 1 | Memory cycle active |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 32 | Byte address of the cycle |
| bus_size | output | 2 | Unit size code of the cycle |
| bus_wdata | output | 32 | Write data, low bytes significant |
| bus_rdata | input | 32 | Read data, valid the cycle after the read |
| ch_done | output | 4 | Per-channel completion flags |

## Verification
Two things can coincide on one channel: a fresh trigger can land in the very cycle whose write completes the channel's last unit. The bench arms a channel with a count of one and fires it. It then watches the bus from the falling edge, and pulses the same request line while the write cycle is on the bus. A correct design shows exactly two bus cycles in total, a set done flag and an untouched next destination byte. A second coincidence, two channels requesting in the same cycle, is checked by the order of the logged read addresses.

// File: rtl/udma_pkg.sv
package udma_pkg;
  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  localparam logic [1:0] STEP_BOTH = 2'd0;
  localparam logic [1:0] STEP_DST  = 2'd1;
  localparam logic [1:0] STEP_SRC  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_state_t;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    unit_bytes = 3'd1;
      2'd1:    unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/udma_chan.sv
module udma_chan
  import udma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          trig,
  input  logic          grant,
  input  logic          step,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [1:0]    size_o,
  output logic          pend_o,
  output logic          done_o
);
  logic [AW-1:0] src_q, dst_q, inc;
  logic [CW-1:0] cnt_q;
  logic [1:0]    size_q, mode_q;
  logic          pend_q, done_q, last, cnt_wr;
  logic          unused_hi;

  assign unused_hi = ^wr_data[AW-1:CW];
  assign inc    = AW'(unit_bytes(size_q));
  assign last   = step && (cnt_q == CW'(1));
  assign cnt_wr = wr_en && (wr_sel == SEL_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      size_q <= '0;
      mode_q <= '0;
      done_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_SRC: src_q <= wr_data;
        SEL_DST: dst_q <= wr_data;
        SEL_CNT: begin
          cnt_q  <= wr_data[CW-1:0];
          done_q <= 1'b0;
        end
        default: begin
          size_q <= wr_data[1:0];
          mode_q <= wr_data[3:2];
        end
      endcase
    end else if (step) begin
      cnt_q <= cnt_q - CW'(1);
      if (mode_q != STEP_DST) src_q <= src_q + inc;
      if (mode_q != STEP_SRC) dst_q <= dst_q + inc;
      if (last) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pend_q <= 1'b0;
    else if (cnt_wr || last) pend_q <= 1'b0;
    else                    pend_q <= (pend_q && !grant) || (trig && cnt_q != '0);
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign size_o = size_q;
  assign pend_o = pend_q;
  assign done_o = done_q;

  a_r6_done_excludes_pend: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && pend_q));
  a_r10_no_step_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cnt_q != '0);
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !wr_en) |=> done_q);
endmodule

// File: rtl/udma_prio.sv
module udma_prio #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign gnt[i] = req[i];
    end else begin : g_rest
      assign gnt[i] = req[i] && !(|req[i-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end

  assign any = |req;

  always_comb begin
    a_r8_grant_within_req: assert ((gnt & ~req) == '0);
    a_r8_single_grant: assert ($onehot0(gnt));
  end
endmodule

// File: rtl/udma_quad.sv
module udma_quad
  import udma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_data,
  input  logic [NCH-1:0] irq_req,
  output logic           cpu_hold,
  output logic           bus_req,
  output logic           bus_wr,
  output logic [AW-1:0]  bus_addr,
  output logic [1:0]     bus_size,
  output logic [AW-1:0]  bus_wdata,
  input  logic [AW-1:0]  bus_rdata,
  output logic [NCH-1:0] ch_done
);
  xfer_state_t   state_q;
  logic [IW-1:0] cur_q, pick;
  logic [NCH-1:0] pend, gnt;
  logic          any;
  logic [AW-1:0] src_v [NCH];
  logic [AW-1:0] dst_v [NCH];
  logic [1:0]    size_v [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    udma_chan #(.AW(AW), .CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we && cfg_ch == IW'(i)),
      .wr_sel (cfg_sel),
      .wr_data(cfg_data),
      .trig   (irq_req[i]),
      .grant  (state_q == ST_IDLE && gnt[i]),
      .step   (state_q == ST_WR && cur_q == IW'(i)),
      .src_o  (src_v[i]),
      .dst_o  (dst_v[i]),
      .size_o (size_v[i]),
      .pend_o (pend[i]),
      .done_o (ch_done[i])
    );
  end

  udma_prio #(.N(NCH)) u_prio (
    .req(pend),
    .gnt(gnt),
    .idx(pick),
    .any(any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (any) begin
          cur_q   <= pick;
          state_q <= ST_RD;
        end
        ST_RD:   state_q <= ST_WR;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_hold  = state_q != ST_IDLE;
  assign bus_req   = state_q == ST_RD || state_q == ST_WR;
  assign bus_wr    = state_q == ST_WR;
  assign bus_addr  = (state_q == ST_WR) ? dst_v[cur_q] : src_v[cur_q];
  assign bus_size  = size_v[cur_q];
  assign bus_wdata = (state_q == ST_WR) ? bus_rdata : '0;

  a_r9_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> (bus_req && bus_wr));
  a_r9_hold_covers_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> cpu_hold);
  a_r9_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr) |=> !bus_req);
  a_r6_done_only_rises_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ch_done) != '0) |-> $past(bus_wr));
endmodule

// File: tb/udma_quad_test.sv
module udma_quad_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0, cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic [3:0]  irq_req = '0;
  logic        cpu_hold, bus_req, bus_wr;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [1:0]  bus_size;
  logic [3:0]  ch_done;

  int checks = 0, errors = 0;
  int bus_cnt = 0, hold_cnt = 0, rd_n = 0;
  logic [7:0] mem [256];
  logic [7:0] rd_log [64];

  always #4 clk = ~clk;

  udma_quad uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .irq_req(irq_req), .cpu_hold(cpu_hold), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ch_done(ch_done)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (cpu_hold) hold_cnt++;
    if (bus_req) begin
      bus_cnt++;
      if (bus_wr) begin
        mem[bus_addr[7:0]] <= bus_wdata[7:0];
        if (bus_size != 2'd0) mem[8'(bus_addr[7:0] + 8'd1)] <= bus_wdata[15:8];
        if (bus_size[1]) begin
          mem[8'(bus_addr[7:0] + 8'd2)] <= bus_wdata[23:16];
          mem[8'(bus_addr[7:0] + 8'd3)] <= bus_wdata[31:24];
        end
      end else begin
        rd_log[rd_n % 64] = bus_addr[7:0];
        rd_n++;
        bus_rdata <= {mem[8'(bus_addr[7:0] + 8'd3)], mem[8'(bus_addr[7:0] + 8'd2)],
                      mem[8'(bus_addr[7:0] + 8'd1)], mem[bus_addr[7:0]]};
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [3:0] m);
    @(negedge clk);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
    wait_cyc(5);
  endtask

  task automatic t_reset;
    chk(cpu_hold == 0 && bus_req == 0, "R1 idle after reset", {cpu_hold, bus_req}, 0);
    chk(ch_done == 0, "R1 done clear", ch_done, 0);
  endtask

  task automatic t_unarmed;
    int b0 = bus_cnt;
    fire(4'b0100);
    chk(bus_cnt == b0, "R10 zero count ignores trigger", bus_cnt - b0, 0);
  endtask

  task automatic t_byte_both;
    int h0 = hold_cnt;
    cfg(0, 0, 32'h10); cfg(0, 1, 32'h80); cfg(0, 3, 32'h0); cfg(0, 2, 32'd3);
    fire(4'b0001);
    chk(mem[8'h80] == pat(8'h10), "R2 one byte moved", mem[8'h80], pat(8'h10));
    chk(mem[8'h81] == 8'h00, "R2 only one unit per trigger", mem[8'h81], 0);
    chk(hold_cnt - h0 == 2, "R9 hold two cycles per transfer", hold_cnt - h0, 2);
    chk(ch_done[0] == 0, "R6 not done with count left", ch_done[0], 0);
    fire(4'b0001); fire(4'b0001);
    for (int k = 1; k < 3; k++)
      chk(mem[8'(8'h80 + k)] == pat(8'h10 + k), "R2 byte copy, both step", mem[8'(8'h80 + k)], pat(8'h10 + k));
    chk(mem[8'h83] == 8'h00, "R3 byte size stops at count", mem[8'h83], 0);
    chk(ch_done[0] == 1, "R6 done at zero", ch_done[0], 1);
  endtask

  task automatic t_after_done;
    int b0 = bus_cnt;
    fire(4'b0001);
    chk(bus_cnt == b0, "R6 done channel ignores trigger", bus_cnt - b0, 0);
  endtask

  task automatic t_half_dst;
    cfg(1, 0, 32'h20); cfg(1, 1, 32'h90); cfg(1, 3, 32'h5); cfg(1, 2, 32'd2);
    fire(4'b0010); fire(4'b0010);
    for (int k = 0; k < 4; k++)
      chk(mem[8'(8'h90 + k)] == pat(8'h20 + (k % 2)), "R4 fixed source, half units R3",
          mem[8'(8'h90 + k)], pat(8'h20 + (k % 2)));
  endtask

  task automatic t_word_src;
    cfg(2, 0, 32'h30); cfg(2, 1, 32'hA0); cfg(2, 3, 32'hA); cfg(2, 2, 32'd2);
    fire(4'b0100); fire(4'b0100);
    for (int k = 0; k < 4; k++)
      chk(mem[8'(8'hA0 + k)] == pat(8'h34 + k), "R5 fixed destination, word units R3",
          mem[8'(8'hA0 + k)], pat(8'h34 + k));
    chk(mem[8'hA4] == 8'h00, "R5 destination never steps", mem[8'hA4], 0);
  endtask

  task automatic t_priority;
    int r0;
    cfg(3, 0, 32'h40); cfg(3, 1, 32'hB0); cfg(3, 3, 32'h0); cfg(3, 2, 32'd1);
    chk(ch_done[1] == 1, "R6 channel 1 done before re-arm", ch_done[1], 1);
    cfg(1, 2, 32'd1);
    chk(ch_done[1] == 0, "R7 count write clears done", ch_done[1], 0);
    r0 = rd_n;
    fire(4'b1010);
    wait_cyc(4);
    chk(rd_n - r0 == 2, "R8 both channels served", rd_n - r0, 2);
    chk(rd_log[r0 % 64] == 8'h20, "R8 lower channel first", rd_log[r0 % 64], 8'h20);
    chk(rd_log[(r0 + 1) % 64] == 8'h40, "R8 higher channel second", rd_log[(r0 + 1) % 64], 8'h40);
    chk(mem[8'hB0] == pat(8'h40), "R8 channel 3 data", mem[8'hB0], pat(8'h40));
    chk(ch_done[3] && ch_done[1], "R7 re-armed channel completes", ch_done, 4'hA);
  endtask

  task automatic t_last_edge;
    int b0;
    cfg(0, 2, 32'd1);
    b0 = bus_cnt;
    @(negedge clk);
    irq_req = 4'b0001;
    @(negedge clk);
    irq_req = '0;
    while (!(bus_req && bus_wr)) @(negedge clk);
    irq_req = 4'b0001;
    @(negedge clk);
    irq_req = '0;
    wait_cyc(6);
    chk(bus_cnt - b0 == 2, "R11 trigger on final write dropped", bus_cnt - b0, 2);
    chk(mem[8'h83] == pat(8'h13), "R11 final unit moved", mem[8'h83], pat(8'h13));
    chk(mem[8'h84] == 8'h00, "R11 no extra unit", mem[8'h84], 0);
    chk(ch_done[0] == 1, "R11 done set", ch_done[0], 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i < 8'h80) ? pat(i) : 8'h00;
    for (int i = 0; i < 64; i++) rd_log[i] = '0;
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_unarmed();
    t_byte_both();
    t_after_done();
    t_half_dst();
    t_word_src();
    t_priority();
    t_last_edge();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule